// File: doc/BRIEF.md
# Dual-I/O Execute-in-Place Flash Read Controller

This block lets a processor read a serial NOR flash as if it were ordinary memory. It is a pipelined bus slave. The flash is assumed to sit in its continuous dual-I/O read mode. In that mode each memory-mapped read is a short frame: chip select falls, the address and a mode byte go out two bits per serial clock with no command byte, a few dummy clocks let the data pins turn around, and the 32-bit word comes back two bits per clock.

A second strobe on the same bus, the configuration port, hands the serial lines to software one byte at a time. Control bits in each written word choose between single-wire and two-wire transfers and between driving and releasing the data pins. Another control bit says whether chip select stays low after the byte. Software uses this port to leave continuous mode, send commands such as an ID read, and later restore continuous mode by sending the dual-I/O read command 0xBB, an address and the mode byte 0xA0. Memory-mapped reads must not be issued while a configuration command holds chip select low.

Top module: `dxip_flash_ctrl`

## Requirements
- R1: After reset, CS_n is high, SCK is low, both data pins are released (oe = 00), and STALL and ACK are low.
- R2: A memory read (CYC, STB, !WE) is accepted on an edge where STALL is low. It drops CS_n and then sends the 24-bit address MSB first, followed by the mode byte 0xA0. Each bit pair goes out on dq[1:0] with dq[1] as the more significant bit, both pins are driven (oe = 11), and no command byte is sent.
- R3: After the mode byte come DUMMY_BEATS SCK periods with both pins released (oe = 00). Then 16 SCK periods sample dq_i at each SCK rising edge, and the 32-bit word, first pair in bits [31:30], is on the read data port in the ACK cycle.
- R4: SCK is low whenever CS_n is high. Each SCK half period lasts CLK_DIV clocks, the first rising edge comes CLK_DIV clocks after CS_n falls, and outputs change only at SCK falling edges.
- R5: A memory read's ACK rises exactly 2*CLK_DIV*(32+DUMMY_BEATS) clocks after the accepting edge, lasts one cycle, and carries valid data in that cycle.
- R6: STALL is high from the accepting edge until the ACK cycle, when it is low. A request held pending during a read is accepted on the edge ending the ACK cycle, so CS_n is high for exactly one clock between back-to-back reads.
- R7: A configuration write with bit 12 set and bit 10 clear sends the byte in bits [7:0] MSB first on dq[0] only (oe = 01) over 8 SCK periods while sampling dq_i[1]. ACK comes 16*CLK_DIV clocks after acceptance, and CS_n stays low afterwards.
- R8: A configuration write with bits 12 and 10 set moves the byte in 4 two-bit SCK periods. If bit 11 is set, both pins are driven with the byte (oe = 11). If bit 11 is clear, both pins are released (oe = 00) and two bits are sampled per rising edge.
- R9: A configuration write with bit 12 clear raises CS_n, produces no SCK edge, and is acknowledged in the cycle right after acceptance.
- R10: A configuration read is acknowledged in the cycle after acceptance with no SCK activity. It returns the byte received by the last configuration transfer in bits [7:0], with all upper bits zero.
- R11: A memory-port write is acknowledged in the cycle after acceptance and has no effect on CS_n or SCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | System clock |
| i_rst_n | input | 1 | Active-low synchronous reset |
| i_wb_cyc | input | 1 | Bus cycle active |
| i_wb_stb | input | 1 | Memory-port strobe |
| i_cfg_stb | input | 1 | Configuration-port strobe |
| i_wb_we | input | 1 | Write enable |
| i_wb_addr | input | ADDR_W | Flash byte address |
| i_wb_data | input | DATA_W | Write data / configuration word |
| o_wb_stall | output | 1 | Request not accepted this cycle |
| o_wb_ack | output | 1 | Request complete; read data valid |
| o_wb_data | output | DATA_W | Read data |
| o_sck | output | 1 | Serial clock to flash |
| o_cs_n | output | 1 | Active-low flash select |
| o_dq | output | 2 | Data pin output values |
| o_dq_oe | output | 2 | Data pin output enables |
| i_dq | input | 2 | Data pin input values |

## Verification
Memory reads are issued at fixed corner addresses (all zeros, all ones and the two alternating patterns) and at seeded random addresses. A small flash model decodes the address bits it sees and returns a word computed from them, so a swapped bit pair, an early or late sample, or a wrong mode byte shows up as a data or decode mismatch. Back-to-back reads with the second request held during the first separate the pending-acceptance behaviour from single reads. Configuration beats in single-wire, dual-drive and dual-release modes separate the pin-enable and sampling choices, and the zero-clock operations (chip-select release, configuration read, memory write) confirm that no serial clock is produced.

// File: rtl/dxip_pkg.sv
package dxip_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_CFG
  } dxip_state_e;

  // configuration word control bits
  localparam int CFG_HOLD_BIT  = 12;
  localparam int CFG_DRIVE_BIT = 11;
  localparam int CFG_DUAL_BIT  = 10;

  localparam int MODE_BEATS = 4;

  // SCK periods in one memory-mapped read frame
  function automatic int unsigned frame_beats(input int unsigned aw,
                                              input int unsigned nd,
                                              input int unsigned dw);
    return aw / 2 + MODE_BEATS + nd + dw / 2;
  endfunction

  // clocks from acceptance edge to the edge that raises ACK
  function automatic int unsigned frame_cycles(input int unsigned div,
                                               input int unsigned aw,
                                               input int unsigned nd,
                                               input int unsigned dw);
    return 2 * div * frame_beats(aw, nd, dw);
  endfunction

  function automatic int unsigned cfg_beats(input logic dual);
    return dual ? 4 : 8;
  endfunction

endpackage

// File: rtl/dxip_sck_gen.sv
module dxip_sck_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int HW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [HW-1:0] hcnt;
  logic          half_tick;

  assign half_tick = run && (hcnt == HW'(DIV - 1));
  assign sck_rise  = half_tick && !sck;
  assign sck_fall  = half_tick && sck;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hcnt <= '0;
      sck  <= 1'b0;
    end else if (half_tick) begin
      hcnt <= '0;
      sck  <= ~sck;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R4
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> (sck != $past(sck)));

  // R4
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_tick) |=> $stable(sck));

endmodule

// File: rtl/dxip_shift.sv
module dxip_shift #(
  parameter int SW = 32,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  input  logic          dual,
  input  logic          shift_out,
  input  logic          shift_in,
  input  logic [1:0]    din,
  output logic [1:0]    dout,
  output logic [RW-1:0] rx
);
  logic [SW-1:0] sreg;

  assign dout = dual ? sreg[SW-1 -: 2] : {1'b0, sreg[SW-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      rx   <= '0;
    end else begin
      if (load)
        sreg <= load_val;
      else if (shift_out)
        sreg <= dual ? {sreg[SW-3:0], 2'b00} : {sreg[SW-2:0], 1'b0};
      if (shift_in)
        rx <= dual ? {rx[RW-3:0], din} : {rx[RW-2:0], din[1]};
    end
  end

endmodule

// File: rtl/dxip_flash_ctrl.sv
module dxip_flash_ctrl
  import dxip_pkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int DUMMY_BEATS = 4,
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter logic [7:0] MODE_CONT = 8'hA0
) (
  input  logic              i_clk,
  input  logic              i_rst_n,
  input  logic              i_wb_cyc,
  input  logic              i_wb_stb,
  input  logic              i_cfg_stb,
  input  logic              i_wb_we,
  input  logic [ADDR_W-1:0] i_wb_addr,
  input  logic [DATA_W-1:0] i_wb_data,
  output logic              o_wb_stall,
  output logic              o_wb_ack,
  output logic [DATA_W-1:0] o_wb_data,
  output logic              o_sck,
  output logic              o_cs_n,
  output logic [1:0]        o_dq,
  output logic [1:0]        o_dq_oe,
  input  logic [1:0]        i_dq
);
  localparam int ADDR_BEATS = ADDR_W / 2;
  localparam int DATA_BEATS = DATA_W / 2;
  localparam int SW         = ADDR_W + 8;
  localparam int BW         = $clog2(ADDR_BEATS + DUMMY_BEATS + DATA_BEATS + 1);

  dxip_state_e       state;
  logic [BW-1:0]     bcnt;
  logic              dual;
  logic              ack_q;
  logic [DATA_W-1:0] dat_q;
  logic [7:0]        rx_byte;
  logic              cs_n_q;
  logic [1:0]        oe_q;

  // named request events
  logic req_ok, mem_acc, mem_wr, cfg_sel, cfg_rd, cfg_go, cfg_end;
  logic cfg_hold, cfg_dual, cfg_drive;
  logic sck_rise, sck_fall, run;
  logic load;
  logic [SW-1:0] load_val;
  logic [DATA_W-1:0] rx;
  logic unused_cfg_bits;

  assign cfg_hold  = i_wb_data[CFG_HOLD_BIT];
  assign cfg_dual  = i_wb_data[CFG_DUAL_BIT];
  assign cfg_drive = i_wb_data[CFG_DRIVE_BIT];
  assign unused_cfg_bits = ^{i_wb_data[DATA_W-1:CFG_HOLD_BIT+1], i_wb_data[CFG_DUAL_BIT-1:8]};

  assign req_ok  = i_wb_cyc && (state == ST_IDLE);
  assign mem_acc = req_ok && i_wb_stb && !i_wb_we;
  assign mem_wr  = req_ok && i_wb_stb && i_wb_we;
  assign cfg_sel = req_ok && !i_wb_stb && i_cfg_stb;
  assign cfg_rd  = cfg_sel && !i_wb_we;
  assign cfg_go  = cfg_sel && i_wb_we && cfg_hold;
  assign cfg_end = cfg_sel && i_wb_we && !cfg_hold;

  assign run      = (state != ST_IDLE);
  assign load     = mem_acc || cfg_go;
  assign load_val = mem_acc ? {i_wb_addr, MODE_CONT}
                            : {i_wb_data[7:0], {(SW-8){1'b0}}};

  dxip_sck_gen #(.DIV(CLK_DIV)) u_sck (
    .clk      (i_clk),
    .rst_n    (i_rst_n),
    .run      (run),
    .sck      (o_sck),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  dxip_shift #(.SW(SW), .RW(DATA_W)) u_shift (
    .clk       (i_clk),
    .rst_n     (i_rst_n),
    .load      (load),
    .load_val  (load_val),
    .dual      (dual),
    .shift_out (sck_fall),
    .shift_in  (sck_rise),
    .din       (i_dq),
    .dout      (o_dq),
    .rx        (rx)
  );

  always_ff @(posedge i_clk) begin
    if (!i_rst_n) begin
      state   <= ST_IDLE;
      bcnt    <= '0;
      dual    <= 1'b0;
      ack_q   <= 1'b0;
      dat_q   <= '0;
      rx_byte <= '0;
      cs_n_q  <= 1'b1;
      oe_q    <= 2'b00;
    end else begin
      ack_q <= 1'b0;
      if (state == ST_IDLE) begin
        if (mem_acc) begin
          state  <= ST_ADDR;
          cs_n_q <= 1'b0;
          oe_q   <= 2'b11;
          dual   <= 1'b1;
          bcnt   <= BW'(ADDR_BEATS - 1);
        end else if (mem_wr) begin
          ack_q <= 1'b1;
        end else if (cfg_rd) begin
          ack_q <= 1'b1;
          dat_q <= {{(DATA_W-8){1'b0}}, rx_byte};
        end else if (cfg_go) begin
          state  <= ST_CFG;
          cs_n_q <= 1'b0;
          dual   <= cfg_dual;
          oe_q   <= cfg_dual ? {cfg_drive, cfg_drive} : 2'b01;
          bcnt   <= BW'(cfg_beats(cfg_dual) - 1);
        end else if (cfg_end) begin
          cs_n_q <= 1'b1;
          ack_q  <= 1'b1;
        end
      end else if (sck_fall) begin
        if (bcnt != '0) begin
          bcnt <= bcnt - 1'b1;
        end else begin
          unique case (state)
            ST_ADDR: begin
              state <= ST_MODE;
              bcnt  <= BW'(MODE_BEATS - 1);
            end
            ST_MODE: begin
              state <= ST_DUMMY;
              oe_q  <= 2'b00;
              bcnt  <= BW'(DUMMY_BEATS - 1);
            end
            ST_DUMMY: begin
              state <= ST_DATA;
              bcnt  <= BW'(DATA_BEATS - 1);
            end
            ST_DATA: begin
              state  <= ST_IDLE;
              cs_n_q <= 1'b1;
              ack_q  <= 1'b1;
              dat_q  <= rx;
            end
            ST_CFG: begin
              state   <= ST_IDLE;
              oe_q    <= 2'b00;
              ack_q   <= 1'b1;
              rx_byte <= rx[7:0];
              dat_q   <= {{(DATA_W-8){1'b0}}, rx[7:0]};
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign o_wb_stall = run;
  assign o_wb_ack   = ack_q;
  assign o_wb_data  = dat_q;
  assign o_cs_n     = cs_n_q;
  assign o_dq_oe    = oe_q;

  // R4
  sck_idle_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_cs_n |-> !o_sck);

  // R2
  addr_drive_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (state == ST_ADDR || state == ST_MODE) |-> (o_dq_oe == 2'b11));

  // R3
  dummy_release_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (state == ST_DUMMY) |-> (o_dq_oe == 2'b00));

  // R6
  accept_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    mem_acc |=> (!o_cs_n && o_wb_stall && !o_wb_ack));

  // R9
  cfg_end_chk: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    cfg_end |=> (o_cs_n && o_wb_ack && !o_sck));

endmodule

// File: tb/dxip_flash_ctrl_tb.sv
module dxip_flash_ctrl_tb_top;
  localparam int DIV = 2;
  localparam int ND  = 4;
  localparam int RD_LAT = 2 * DIV * (12 + 4 + ND + 16);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, cstb = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdat = '0;
  logic stall, ack, sck, csn;
  logic [31:0] rdat;
  logic [1:0] dq, oe, fdq;

  int checks = 0, fails = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  // flash model state
  bit mem_mode = 1'b1;
  int mbeats = 0;
  logic [31:0] mcap = '0;
  logic [1:0] mem_bits = '0;
  int oe_err = 0, per_err = 0;
  realtime t_last = 0;
  logic [7:0] rep_sh = '0;
  bit rep_dual = 1'b0;
  logic [1:0] exp_cfg_oe = '0;
  logic [7:0] cfg_cap = '0;
  int rises = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  dxip_flash_ctrl #(.CLK_DIV(DIV), .DUMMY_BEATS(ND)) dut_i (
    .i_clk(clk), .i_rst_n(rst_n), .i_wb_cyc(cyc), .i_wb_stb(stb),
    .i_cfg_stb(cstb), .i_wb_we(we), .i_wb_addr(addr), .i_wb_data(wdat),
    .o_wb_stall(stall), .o_wb_ack(ack), .o_wb_data(rdat),
    .o_sck(sck), .o_cs_n(csn), .o_dq(dq), .o_dq_oe(oe), .i_dq(fdq));

  function automatic logic [31:0] fword(input logic [23:0] a);
    return ({8'd0, a} * 32'h9E37_79B1) ^ 32'h5A5A_0FF0;
  endfunction

  assign fdq = mem_mode ? mem_bits : (rep_dual ? rep_sh[7:6] : {rep_sh[7], 1'b0});

  always @(negedge csn) begin
    mbeats = 0;
    t_last = $realtime;
  end

  always @(posedge sck) begin
    rises++;
    if (mem_mode) begin
      if ($realtime - t_last != DIV * 4) per_err++;
      if (mbeats < 16) begin
        mcap = {mcap[29:0], dq};
        if (oe != 2'b11) oe_err++;
      end else if (oe != 2'b00) oe_err++;
      mbeats++;
    end else begin
      cfg_cap = rep_dual ? {cfg_cap[5:0], dq} : {cfg_cap[6:0], dq[0]};
      if (oe != exp_cfg_oe) oe_err++;
    end
    t_last = $realtime;
  end

  always @(negedge sck) begin
    if (mem_mode) begin
      if ($realtime - t_last != DIV * 4) per_err++;
      if (mbeats >= 16 + ND && mbeats < 32 + ND)
        mem_bits = fword(mcap[31:8]) >> (30 - 2 * (mbeats - 16 - ND));
    end else begin
      rep_sh = rep_dual ? {rep_sh[5:0], 2'b00} : {rep_sh[6:0], 1'b0};
    end
    t_last = $realtime;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // present a request and wait for its acceptance; returns cycle count after the accepting edge
  task automatic issue(input bit is_cfg, input bit w, input logic [23:0] a,
                       input logic [31:0] d, output int acc);
    cyc = 1'b1; stb = !is_cfg; cstb = is_cfg; we = w; addr = a; wdat = d;
    while (stall) @(negedge clk);
    acc = cyc_cnt + 1;
    @(negedge clk);
    stb = 1'b0; cstb = 1'b0;
  endtask

  task automatic wait_ack(input int acc, output int lat);
    while (!ack) @(negedge clk);
    lat = cyc_cnt - acc;
  endtask

  task automatic mem_read(input logic [23:0] a);
    int acc, lat;
    mem_mode = 1'b1; oe_err = 0; per_err = 0;
    issue(1'b0, 1'b0, a, 32'd0, acc);
    chk(stall && !csn, "R6 stall/cs after accept", {30'd0, stall, csn}, 32'h2);
    wait_ack(acc, lat);
    chk(lat == RD_LAT, "R5 read latency", lat, RD_LAT);
    chk(rdat == fword(a), "R3 read data", rdat, fword(a));
    chk(mcap[31:8] == a, "R2 address decode", mcap[31:8], a);
    chk(mcap[7:0] == 8'hA0, "R2 mode byte", mcap[7:0], 32'hA0);
    chk(oe_err == 0, "R3 pin enables", oe_err, 0);
    chk(per_err == 0, "R4 half period", per_err, 0);
    chk(csn && !stall, "R6 ack cycle", {30'd0, csn, stall}, 32'h2);
    @(negedge clk);
    chk(!ack, "R5 single-cycle ack", ack, 0);
    cyc = 1'b0;
  endtask

  task automatic cfg_xfer(input logic [31:0] word, input logic [7:0] reply, input bit dl,
                          input logic [1:0] eoe, input int exp_lat, input string req);
    int acc, lat, r0;
    mem_mode = 1'b0; rep_sh = reply; rep_dual = dl; exp_cfg_oe = eoe;
    cfg_cap = '0; oe_err = 0; r0 = rises;
    issue(1'b1, 1'b1, 24'd0, word, acc);
    wait_ack(acc, lat);
    chk(lat == exp_lat, req, lat, exp_lat);
    chk(rises - r0 == (exp_lat == 0 ? 0 : (dl ? 4 : 8)), req, rises - r0, dl ? 4 : 8);
    if (exp_lat != 0) begin
      chk(cfg_cap == word[7:0], req, cfg_cap, word[7:0]);
      chk(oe_err == 0, req, oe_err, 0);
      chk(!csn, req, csn, 0);
    end else begin
      chk(csn && !sck, req, {30'd0, csn, sck}, 32'h2);
    end
    @(negedge clk);
    cyc = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] exp);
    int acc, lat, r0;
    r0 = rises;
    issue(1'b1, 1'b0, 24'd0, 32'd0, acc);
    wait_ack(acc, lat);
    chk(lat == 0, "R10 cfg read latency", lat, 0);
    chk(rdat == {24'd0, exp}, "R10 cfg read data", rdat, {24'd0, exp});
    chk(rises == r0, "R10 no sck", rises - r0, 0);
    @(negedge clk);
    cyc = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R5 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int acc1, acc2, lat, r0;
    logic [23:0] corners [4];
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(csn && !sck && oe == 2'b00 && !stall && !ack, "R1 reset state",
        {27'd0, csn, sck, oe, stall}, 32'h10);

    corners = '{24'h000000, 24'hFFFFFF, 24'hAAAAAA, 24'h555555};
    foreach (corners[i]) mem_read(corners[i]);
    for (int i = 0; i < 10; i++) mem_read(24'($urandom()));

    // R6 back-to-back with pending second request
    mem_mode = 1'b1;
    cyc = 1'b1; stb = 1'b1; we = 1'b0; addr = 24'h123456;
    while (stall) @(negedge clk);
    acc1 = cyc_cnt + 1;
    @(negedge clk);
    addr = 24'hFEDCBA;
    chk(stall, "R6 pending request stalled", stall, 1);
    wait_ack(acc1, lat);
    chk(lat == RD_LAT && rdat == fword(24'h123456), "R6 first of pair", rdat, fword(24'h123456));
    chk(csn && !stall, "R6 gap cycle", {30'd0, csn, stall}, 32'h2);
    acc2 = cyc_cnt + 1;
    @(negedge clk);
    chk(!csn && stall, "R6 immediate acceptance", {30'd0, csn, stall}, 32'h1);
    stb = 1'b0;
    wait_ack(acc2, lat);
    chk(lat == RD_LAT && rdat == fword(24'hFEDCBA), "R6 second of pair", rdat, fword(24'hFEDCBA));
    @(negedge clk);
    cyc = 1'b0;

    // R7 single-wire command with hold, flash answers 0xEF on dq[1]
    cfg_xfer(32'h0000_109F, 8'hEF, 1'b0, 2'b01, 2 * DIV * 8, "R7 single cfg beat");
    cfg_read(8'hEF);
    // R8 dual drive and dual release
    cfg_xfer(32'h0000_1CBB, 8'h00, 1'b1, 2'b11, 2 * DIV * 4, "R8 dual drive beat");
    rep_sh = 8'h5C;
    cfg_xfer(32'h0000_1400, 8'h5C, 1'b1, 2'b00, 2 * DIV * 4, "R8 dual release beat");
    cfg_read(8'h5C);
    // R9 release chip select
    cfg_xfer(32'h0000_0000, 8'h00, 1'b0, 2'b00, 0, "R9 cs release");

    // R11 memory write ignored
    r0 = rises;
    issue(1'b0, 1'b1, 24'h00BEEF, 32'hDEAD_BEEF, acc1);
    wait_ack(acc1, lat);
    chk(lat == 0, "R11 write ack latency", lat, 0);
    chk(csn && !sck && rises == r0, "R11 no pin activity", rises - r0, 0);
    @(negedge clk);
    cyc = 1'b0;
    mem_read(24'h00BEEF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule